// File: doc/BRIEF.md
# Bidirectional Timer Counter with Byte-Access Latch

This block is a 16-bit timer counter that a processor reaches over an 8-bit bus. The count can run up and wrap, or run up and down between zero and a limit. Because the bus is only one byte wide, a shared high-byte holding register makes each 16-bit read or write atomic. Reading the low byte captures the high byte at the same instant. Writing the low byte commits the held high byte together with the new low byte.

The counter steps only on a qualified timer tick. A 3-bit clock-select field picks the tick source. The source is either every cycle, one of four taps of a free-running prescaler, or the rising or falling edges of a synchronized external pin. A select value of zero stops counting, but bus access still works. A sticky overflow flag records wrap events. Software clears the flag by writing a one to it. An external retrigger pulse makes the counter act as if it had reached its limit. Two outputs report when the count sits at the limit or at zero.

Top module: `bicount16`

## Requirements
- R1: After reset the count, the holding register, the clock select, the mode bit and the overflow flag are all zero, and the direction is up.
- R2: Bus addresses are 0 = count low byte, 1 = high-byte holding register, 2 = status (bit 0 is the overflow flag), 3 = control (bits [2:0] clock select, bit 3 mode: 0 up-wrap, 1 up/down). `rdata` is combinational from `addr`.
- R3: A read at address 0 returns the count's low byte and, on that clock edge, copies the count's high byte into the holding register. A read at address 1 returns the holding register.
- R4: A write at address 1 changes only the holding register. A write at address 0 loads the count with {holding register, wdata} in one cycle and sets the direction to up.
- R5: A count load from the bus takes priority over any tick or retrigger in the same cycle.
- R6: With clock select 0 the count never changes except through a bus load or a retrigger.
- R7: Clock select 1 gives a tick every cycle. Selects 2, 3, 4 and 5 give one tick every 8, 64, 256 and 1024 cycles of a free-running prescaler.
- R8: Select 6 ticks on falling edges and select 7 ticks on rising edges of `ext_in`, after a two-flop synchronizer.
- R9: In up-wrap mode, a tick at count == `top_lim` loads zero and sets the flag. Any other tick adds one.
- R10: In up/down mode, an up tick at `top_lim` turns the direction down and subtracts one. A down tick at zero turns the direction up, loads one and sets the flag. Other ticks step one in the current direction.
- R11: `at_bottom` is high when the count is zero. `at_top` is high when the count equals `top_lim`.
- R12: `retrig` acts at once and overrides a same-cycle tick. In up-wrap mode it clears the count and sets the flag. In up/down mode it turns the direction down and leaves the count unchanged.
- R13: The flag is sticky. Writing status with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it unchanged. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Bus register address |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data |
| top_lim | input | 16 | Count limit (TOP value) |
| retrig | input | 1 | Retrigger request, synchronous |
| ext_in | input | 1 | External count input, asynchronous |
| at_top | output | 1 | Count equals `top_lim` |
| at_bottom | output | 1 | Count equals zero |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is a torn read. In that case the count carries into its high byte between the low-byte read and the high-byte read. Only a running counter caught at the right instant shows it. The stimulus loads a value three below a byte boundary with a tick every cycle. It reads the low byte within two cycles and reads the holding register several cycles later, after the carry has happened. The high byte returned must still match the low byte that was read, not the live count. Bus-load priority is tested the same way: the load lands on a ticking edge, and the low byte is sampled before the next edge.

// File: rtl/bicount_pkg.sv
package bicount_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int CS_W   = 3;

    localparam logic [ADDR_W-1:0] A_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_UPDN = 1'b1
    } mode_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] temp;
        logic              dir_dn;
        logic              ovf;
        logic [CS_W-1:0]   cs;
        mode_e             mode;
    } cnt_state_t;
endpackage

// File: rtl/bicount_ext_edge.sv
module bicount_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     synced;

    assign synced = st_q.sh[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[SYNC_STAGES-2:0], ext_in};
        st_d.prev = synced;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = synced & ~st_q.prev;
    assign fall = ~synced & st_q.prev;
endmodule

// File: rtl/bicount_tick_sel.sv
module bicount_tick_sel
    import bicount_pkg::*;
#(
    parameter int SH_A = 3,
    parameter int SH_B = 6,
    parameter int SH_C = 8,
    parameter int SH_D = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CS_W-1:0] cs,
    input  logic            ext_rise,
    input  logic            ext_fall,
    output logic            tick
);
    localparam int PRE_W = SH_D;
    localparam logic [PRE_W-1:0] M_A = PRE_W'((1 << SH_A) - 1);
    localparam logic [PRE_W-1:0] M_B = PRE_W'((1 << SH_B) - 1);
    localparam logic [PRE_W-1:0] M_C = PRE_W'((1 << SH_C) - 1);
    localparam logic [PRE_W-1:0] M_D = PRE_W'((1 << SH_D) - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [3:0]       tap;

    always_comb begin
        pre_d  = pre_q + PRE_W'(1);
        tap[0] = (pre_q & M_A) == M_A;
        tap[1] = (pre_q & M_B) == M_B;
        tap[2] = (pre_q & M_C) == M_C;
        tap[3] = (pre_q & M_D) == M_D;
        case (cs)
            3'd1:    tick = 1'b1;
            3'd2:    tick = tap[0];
            3'd3:    tick = tap[1];
            3'd4:    tick = tap[2];
            3'd5:    tick = tap[3];
            3'd6:    tick = ext_fall;
            3'd7:    tick = ext_rise;
            default: tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/bicount16.sv
module bicount16
    import bicount_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [CNT_W-1:0]  top_lim,
    input  logic              retrig,
    input  logic              ext_in,
    output logic              at_top,
    output logic              at_bottom,
    output logic              ovf_flag
);
    cnt_state_t st_d, st_q;
    logic set_ovf;
    logic ext_rise, ext_fall, tick_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [BYTE_W-1:0] temp_w;
    logic [CS_W-1:0]   cs_w;

    assign cnt_w  = st_q.cnt;
    assign temp_w = st_q.temp;
    assign cs_w   = st_q.cs;

    bicount_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_in),
        .rise   (ext_rise),
        .fall   (ext_fall)
    );

    bicount_tick_sel tsel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs_w),
        .ext_rise (ext_rise),
        .ext_fall (ext_fall),
        .tick     (tick_w)
    );

    always_comb begin
        st_d    = st_q;
        set_ovf = 1'b0;

        // counting: retrigger first, then a qualified tick
        if (retrig) begin
            if (st_q.mode == MODE_WRAP) begin
                st_d.cnt = '0;
                set_ovf  = 1'b1;
            end else begin
                st_d.dir_dn = 1'b1;
            end
        end else if (tick_w) begin
            if (st_q.mode == MODE_WRAP) begin
                if (st_q.cnt == top_lim) begin
                    st_d.cnt = '0;
                    set_ovf  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end else if (!st_q.dir_dn) begin
                if (st_q.cnt == top_lim) begin
                    st_d.dir_dn = 1'b1;
                    st_d.cnt    = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_W'(1);
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.dir_dn = 1'b0;
                    st_d.cnt    = (top_lim == '0) ? '0 : CNT_W'(1);
                    set_ovf     = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end

        // flag: write-one clear, a set in the same cycle wins
        if (wr_en && addr == A_STAT && wdata[0]) st_d.ovf = 1'b0;
        if (set_ovf) st_d.ovf = 1'b1;

        // low-byte read latches the high byte
        if (rd_en && !wr_en && addr == A_LO) st_d.temp = st_q.cnt[CNT_W-1:BYTE_W];

        // bus writes override all counting
        if (wr_en) begin
            case (addr)
                A_LO: begin
                    st_d.cnt    = {st_q.temp, wdata};
                    st_d.dir_dn = 1'b0;
                end
                A_HI:   st_d.temp = wdata;
                A_CTRL: begin
                    st_d.cs   = wdata[CS_W-1:0];
                    st_d.mode = mode_e'(wdata[CS_W]);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_LO:    rdata = cnt_w[BYTE_W-1:0];
            A_HI:    rdata = temp_w;
            A_STAT:  rdata = {{(BYTE_W-1){1'b0}}, st_q.ovf};
            default: rdata = {{(BYTE_W-CS_W-1){1'b0}}, st_q.mode, cs_w};
        endcase
    end

    assign at_top    = (cnt_w == top_lim);
    assign at_bottom = (cnt_w == '0);
    assign ovf_flag  = st_q.ovf;
endmodule

// File: rtl/bicount_chk.sv
module bicount_chk
    import bicount_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BYTE_W-1:0] wdata,
    input logic              retrig,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [BYTE_W-1:0] temp,
    input logic [CS_W-1:0]   cs,
    input logic              ovf
);
    AST_LOW_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LO) |=> (cnt == {$past(temp), $past(wdata)})); // R4

    AST_LOW_READ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == A_LO) |=> (temp == $past(cnt[CNT_W-1:BYTE_W]))); // R3

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs == '0 && !retrig && !(wr_en && addr == A_LO)) |=> (cnt == $past(cnt))); // R6

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !retrig && !(wr_en && addr == A_LO)) |=>
        ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1)) || (cnt == '0))); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && addr == A_STAT && wdata[0])) |=> ovf); // R13
endmodule

bind bicount16 bicount_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wdata  (wdata),
    .retrig (retrig),
    .tick   (tick_w),
    .cnt    (cnt_w),
    .temp   (temp_w),
    .cs     (cs_w),
    .ovf    (ovf_flag)
);

// File: tb/bicount16_tb_top.sv
module bicount16_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] top_lim = 16'hFFFF;
    logic        retrig = 1'b0;
    logic        ext_in = 1'b0;
    logic        at_top, at_bottom, ovf_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bicount16 dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .top_lim(top_lim), .retrig(retrig),
        .ext_in(ext_in), .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [2:0]  cs;
        logic        mode;
        logic [15:0] top;
        logic [15:0] start;
        logic [7:0]  n;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, 16'hFFFF, 16'h0000, 8'd5, 16'h0005, 1'b0},  // R9 plain up
        '{3'd1, 1'b0, 16'h0010, 16'h000E, 8'd5, 16'h0002, 1'b1},  // R9 wrap at limit
        '{3'd1, 1'b0, 16'hFFFF, 16'h00FE, 8'd3, 16'h0101, 1'b0},  // R9 carry to high byte
        '{3'd1, 1'b1, 16'h0004, 16'h0002, 8'd5, 16'h0001, 1'b0},  // R10 turn at limit
        '{3'd1, 1'b1, 16'h0003, 16'h0002, 8'd6, 16'h0002, 1'b1},  // R10 turn at zero
        '{3'd0, 1'b0, 16'hFFFF, 16'h0ABC, 8'd4, 16'h0ABC, 1'b0}   // R6 stopped
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(2'd0, lo);
        bus_rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic load16(input logic [15:0] v);
        bus_wr(2'd1, v[15:8]);
        bus_wr(2'd0, v[7:0]);
    endtask

    // enables select cs for exactly n clock edges, then stops
    task automatic run_for(input logic mode, input logic [2:0] cs, input int n);
        bus_wr(2'd3, {4'd0, mode, cs});
        repeat (n - 1) @(posedge clk);
        bus_wr(2'd3, {4'd0, mode, 3'd0});
    endtask

    task automatic pulse_retrig();
        @(negedge clk); retrig = 1'b1;
        @(negedge clk); retrig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b, lo, hi;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 at_bottom", at_bottom, 1);
        chk("R1 flag", ovf_flag, 0);
        chk("R11 at_top with limit FFFF", at_top, 0);
        bus_rd(2'd3, b); chk("R1 control", b, 8'h00);
        rd16(v); chk("R1 count", v, 16'h0000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            bus_wr(2'd3, 8'h00);
            top_lim = VECS[i].top;
            load16(VECS[i].start);
            bus_wr(2'd2, 8'h01);
            run_for(VECS[i].mode, VECS[i].cs, int'(VECS[i].n));
            rd16(v);
            chk($sformatf("R9/R10/R6 vec%0d count", i), v, VECS[i].exp_cnt);
            chk($sformatf("R9/R10/R13 vec%0d flag", i), ovf_flag, VECS[i].exp_ovf);
        end

        // R2 control readback
        bus_wr(2'd3, 8'h0A);
        bus_rd(2'd3, b); chk("R2 control readback", b, 8'h0A);
        bus_wr(2'd3, 8'h00);

        // R11 at_top
        top_lim = 16'h0010; load16(16'h0010);
        @(negedge clk); chk("R11 at_top", at_top, 1);
        chk("R11 at_bottom low", at_bottom, 0);
        top_lim = 16'hFFFF;

        // R3 atomic read while running
        load16(16'h00FD);
        bus_wr(2'd3, 8'h01);
        bus_rd(2'd0, lo);
        repeat (6) @(posedge clk);
        bus_rd(2'd1, hi);
        chk("R3 latched high byte", hi, (lo >= 8'hFD) ? 8'h00 : 8'h01);

        // R5 bus load wins over a running tick
        bus_wr(2'd1, 8'h12);
        bus_wr(2'd0, 8'h34);
        addr = 2'd0; #1;
        chk("R5 low after load", rdata, 8'h34);
        bus_rd(2'd0, lo);
        bus_rd(2'd1, hi);
        chk("R4 high after load", hi, 8'h12);
        bus_wr(2'd3, 8'h00);

        // R4 high write touches only the holding register
        load16(16'h5566);
        bus_wr(2'd1, 8'h77);
        bus_rd(2'd0, lo); chk("R4 low unchanged", lo, 8'h66);
        bus_rd(2'd1, hi); chk("R4 high refreshed by low read", hi, 8'h55);

        // R7 prescaler taps
        load16(16'h0000); run_for(1'b0, 3'd2, 80);
        rd16(v); chk("R7 divide by 8", v, 16'd10);
        load16(16'h0000); run_for(1'b0, 3'd3, 128);
        rd16(v); chk("R7 divide by 64", v, 16'd2);

        // R8 external edges
        load16(16'h0000);
        bus_wr(2'd3, 8'h07);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) ext_in = 1'b1; repeat (4) @(negedge clk);
            ext_in = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        bus_wr(2'd3, 8'h00);
        rd16(v); chk("R8 rising edges", v, 16'd4);
        load16(16'h0000);
        bus_wr(2'd3, 8'h06);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) ext_in = 1'b1; repeat (4) @(negedge clk);
            ext_in = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        bus_wr(2'd3, 8'h00);
        rd16(v); chk("R8 falling edges", v, 16'd3);

        // R12 retrigger in up-wrap mode
        bus_wr(2'd2, 8'h01);
        load16(16'h0050);
        pulse_retrig();
        rd16(v); chk("R12 wrap retrig clears", v, 16'h0000);
        chk("R12 wrap retrig flag", ovf_flag, 1);

        // R13 write-one clear
        bus_wr(2'd2, 8'h00); chk("R13 write zero keeps flag", ovf_flag, 1);
        bus_wr(2'd2, 8'h01); chk("R13 write one clears flag", ovf_flag, 0);

        // R12 retrigger in up/down mode
        load16(16'h0010);
        bus_wr(2'd3, 8'h08);
        pulse_retrig();
        rd16(v); chk("R12 updown retrig holds count", v, 16'h0010);
        run_for(1'b1, 3'd1, 3);
        rd16(v); chk("R12 updown retrig turns down", v, 16'h000D);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule